// File: doc/BRIEF.md
# Three-Table Configurable Logic Cell

This block is one programmable logic cell meant to be tiled across a lookup-table fabric. It holds two 16-entry truth tables (called F and G here). Each table is addressed by its own four inputs. A third 8-entry truth table (H) can merge the F and G results. Two selectors pick the two lower H address bits: each takes either the F or G result or a direct input pin. The top H address bit always comes straight from a pin. Because of this, nine-input functions such as 9-bit parity, and any function of five inputs, fit in a single cell. Each output is a plain read of stored bits, so the delay does not depend on the function that is programmed.

Two edge-triggered registers with a shared clock enable capture one of four sources each: F, G, H, or a direct data pin. All table contents and selector settings sit in a 48-bit configuration chain. The chain is loaded serially, most significant bit first, one bit per clock while the configuration enable is high. Its oldest bit appears on a shift-out pin so that cells can be daisy-chained.

Top module: `cfg_logic_cell`

## Requirements
- R1: The F output equals configuration bit 32+n, where n is f_in read as a number (f_in[0] is the address LSB). The G output equals bit 16+n for g_in. With bit 1 clear, x_o shows F; with bit 0 clear, y_o shows G.
- R2: The H address is {h1_in, b, a}, and the H output equals configuration bit 8+address. Input a is the F output when bit 7 is set, else din. Input b is the G output when bit 6 is set, else alt_in.
- R3: x_o shows H when configuration bit 1 is set, and y_o shows H when bit 0 is set.
- R4: While cfg_en is high, each rising clock edge shifts cfg_si into bit 0 and moves every bit one place up. The first bit shifted in ends in bit 47 after 48 edges. cfg_so always shows bit 47. While cfg_en is low, the configuration does not change.
- R5: When ce is high, cfg_en is low and rst is low, qx_o loads the source chosen by bits [5:4] and qy_o loads the source chosen by bits [3:2] at the rising edge. The source codes are 0=F, 1=G, 2=H, 3=din.
- R6: When ce is low, both registers hold their values.
- R7: When cfg_en is high, both registers hold their values, even with ce high.
- R8: A high rst clears both registers to 0 at the next rising edge, whatever ce and cfg_en are. The configuration is kept.
- R9: With F and G holding 4-bit parity, both H selectors taking F and G, H holding 3-bit parity and x_o showing H, x_o is the parity of all nine inputs.
- R10: With g_in tied to f_in, both H selectors taking F and G, and H = 8'hCA (h1_in picks between them), x_o realises any 32-entry function of {h1_in, f_in}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous register clear, active high |
| ce | input | 1 | Register clock enable |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_si | input | 1 | Configuration serial input |
| cfg_so | output | 1 | Configuration serial output (bit 47) |
| f_in | input | 4 | F table address |
| g_in | input | 4 | G table address |
| h1_in | input | 1 | Fixed H address bit 2 |
| din | input | 1 | Direct data: H bit 0 alternative and register source |
| alt_in | input | 1 | Second direct input: H bit 1 alternative |
| x_o | output | 1 | Combinational output, F or H |
| y_o | output | 1 | Combinational output, G or H |
| qx_o | output | 1 | Registered output X |
| qy_o | output | 1 | Registered output Y |

## Verification
On every cycle, the assertions check the sequential rules. These are: the configuration holds while its enable is low and shifts by exactly one place while it is high; reset clears both registers; and the registers freeze when the clock enable is low or a load is running. The combinational table reads, the selector decoding, the register source choice, parity across nine inputs, the five-input mapping, and the survival of the configuration across reset can only be shown by the bench's scenarios. These scenarios load whole images and then sweep the input space against a model.

// File: rtl/lc_pkg.sv
`timescale 1ns/1ps
package lc_pkg;
   localparam int H_ADDR_W = 3;
   localparam int SRC_W    = 2;

   typedef enum logic [SRC_W-1:0] {
      SRC_F   = 2'd0,
      SRC_G   = 2'd1,
      SRC_H   = 2'd2,
      SRC_DIN = 2'd3
   } ff_src_e;
endpackage

// File: rtl/lc_lut.sv
`timescale 1ns/1ps
module lc_lut #(
   parameter int K = 4,
   localparam int DEPTH = 1 << K
) (
   input  logic [DEPTH-1:0] tab,
   input  logic [K-1:0]     addr,
   output logic             y
);
   assign y = tab[addr];
endmodule

// File: rtl/lc_cfg_chain.sv
`timescale 1ns/1ps
module lc_cfg_chain #(
   parameter int W = 48
) (
   input  logic         clk,
   input  logic         shift_en,
   input  logic         si,
   output logic [W-1:0] bits,
   output logic         so
);
   logic [W-1:0] store;

   always_ff @(posedge clk) begin
      if (shift_en) store <= {store[W-2:0], si};
   end

   assign bits = store;
   assign so   = store[W-1];
endmodule

// File: rtl/lc_reg_slot.sv
`timescale 1ns/1ps
module lc_reg_slot
   import lc_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             ce,
   input  logic             hold,
   input  logic [SRC_W-1:0] src,
   input  logic             f_v,
   input  logic             g_v,
   input  logic             h_v,
   input  logic             d_v,
   output logic             q
);
   logic nxt;

   always_comb begin
      case (ff_src_e'(src))
         SRC_F:   nxt = f_v;
         SRC_G:   nxt = g_v;
         SRC_H:   nxt = h_v;
         default: nxt = d_v;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)               q <= 1'b0;
      else if (ce && !hold)  q <= nxt;
   end
endmodule

// File: rtl/cfg_logic_cell.sv
`timescale 1ns/1ps
module cfg_logic_cell
   import lc_pkg::*;
#(
   parameter int K_FG = 4,
   parameter int K_H  = 3,
   parameter int N_REG = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ce,
   input  logic          cfg_en,
   input  logic          cfg_si,
   output logic          cfg_so,
   input  logic [K_FG-1:0] f_in,
   input  logic [K_FG-1:0] g_in,
   input  logic          h1_in,
   input  logic          din,
   input  logic          alt_in,
   output logic          x_o,
   output logic          y_o,
   output logic          qx_o,
   output logic          qy_o
);
   localparam int TAB_FG   = 1 << K_FG;
   localparam int TAB_H    = 1 << K_H;
   localparam int OFF_YSEL = 0;
   localparam int OFF_XSEL = 1;
   localparam int OFF_SRC  = 2;
   localparam int OFF_HB   = OFF_SRC + N_REG*SRC_W;
   localparam int OFF_HA   = OFF_HB + 1;
   localparam int OFF_H    = OFF_HA + 1;
   localparam int OFF_G    = OFF_H + TAB_H;
   localparam int OFF_F    = OFF_G + TAB_FG;
   localparam int CFG_W    = OFF_F + TAB_FG;

   generate
      if (K_H != H_ADDR_W) begin : g_bad_h
         $error("H table must have exactly three address bits");
      end
      if (K_FG < 1 || K_FG > 6) begin : g_bad_fg
         $error("F/G table address width out of range");
      end
      if (N_REG != 2) begin : g_bad_reg
         $error("cell carries exactly two registers");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_bits;
   logic f_v, g_v, h_v, ha, hb;
   logic [N_REG-1:0] slot_q;

   lc_cfg_chain #(.W(CFG_W)) u_chain (
      .clk(clk), .shift_en(cfg_en), .si(cfg_si), .bits(cfg_bits), .so(cfg_so)
   );

   lc_lut #(.K(K_FG)) u_f (.tab(cfg_bits[OFF_F +: TAB_FG]), .addr(f_in), .y(f_v));
   lc_lut #(.K(K_FG)) u_g (.tab(cfg_bits[OFF_G +: TAB_FG]), .addr(g_in), .y(g_v));

   assign ha = cfg_bits[OFF_HA] ? f_v : din;
   assign hb = cfg_bits[OFF_HB] ? g_v : alt_in;

   lc_lut #(.K(K_H)) u_h (.tab(cfg_bits[OFF_H +: TAB_H]), .addr({h1_in, hb, ha}), .y(h_v));

   assign x_o = cfg_bits[OFF_XSEL] ? h_v : f_v;
   assign y_o = cfg_bits[OFF_YSEL] ? h_v : g_v;

   // slot 0 drives qy_o (source bits [3:2]), slot 1 drives qx_o (bits [5:4])
   for (genvar i = 0; i < N_REG; i++) begin : g_slot
      lc_reg_slot u_slot (
         .clk(clk), .rst(rst), .ce(ce), .hold(cfg_en),
         .src(cfg_bits[OFF_SRC + i*SRC_W +: SRC_W]),
         .f_v(f_v), .g_v(g_v), .h_v(h_v), .d_v(din),
         .q(slot_q[i])
      );
   end

   assign qy_o = slot_q[0];
   assign qx_o = slot_q[1];
endmodule

// File: rtl/lc_cell_chk.sv
`timescale 1ns/1ps
module lc_cell_chk #(
   parameter int CFG_W = 48
) (
   input logic             clk,
   input logic             rst,
   input logic             ce,
   input logic             cfg_en,
   input logic             cfg_si,
   input logic [CFG_W-1:0] cfg_q,
   input logic             qx,
   input logic             qy
);
   assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !cfg_en |=> $stable(cfg_q));

   assert_cfg_shift_R4: assert property (@(posedge clk) disable iff (rst)
      cfg_en |=> (cfg_q == {$past(cfg_q[CFG_W-2:0]), $past(cfg_si)}));

   assert_rst_clear_R8: assert property (@(posedge clk)
      rst |=> (qx == 1'b0 && qy == 1'b0));

   assert_ce_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !ce |=> ($stable(qx) && $stable(qy)));

   assert_cfg_lock_R7: assert property (@(posedge clk) disable iff (rst)
      cfg_en |=> ($stable(qx) && $stable(qy)));
endmodule

bind cfg_logic_cell lc_cell_chk #(.CFG_W(CFG_W)) u_chk (
   .clk(clk), .rst(rst), .ce(ce), .cfg_en(cfg_en), .cfg_si(cfg_si),
   .cfg_q(cfg_bits), .qx(qx_o), .qy(qy_o)
);

// File: tb/cfg_logic_cell_tb.sv
`timescale 1ns/1ps
module cfg_logic_cell_tb;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst = 1'b1, ce = 1'b0, cfg_en = 1'b0, cfg_si = 1'b0;
   logic [3:0] f_in = '0, g_in = '0;
   logic h1_in = 1'b0, din = 1'b0, alt_in = 1'b0;
   logic cfg_so, x_o, y_o, qx_o, qy_o;

   cfg_logic_cell u_dut (
      .clk(clk), .rst(rst), .ce(ce), .cfg_en(cfg_en), .cfg_si(cfg_si),
      .cfg_so(cfg_so), .f_in(f_in), .g_in(g_in), .h1_in(h1_in), .din(din),
      .alt_in(alt_in), .x_o(x_o), .y_o(y_o), .qx_o(qx_o), .qy_o(qy_o)
   );

   localparam logic [4:0] M_X = 5'd1, M_Y = 5'd2, M_QX = 5'd4, M_QY = 5'd8, M_SO = 5'd16;

   typedef struct {
      logic x, y, qx, qy, so;
      logic [4:0] m;
      string rc, rq;
   } exp_t;
   exp_t sb[$];

   int total = 0, bad = 0;
   bit done = 0;

   // next-cycle stimulus, applied at the falling edge by tick
   logic n_rst = 1, n_ce = 0, n_en = 0, n_si = 0, n_h1 = 0, n_din = 0, n_alt = 0;
   logic [3:0] n_f = 0, n_g = 0;
   logic ovr_en = 0, ovr_x = 0;
   logic [47:0] mcfg = '0;
   logic mqx = 0, mqy = 0;

   function automatic logic [47:0] mk(logic [15:0] ft, logic [15:0] gt, logic [7:0] ht,
                                      logic ha, logic hb, logic [1:0] sx, logic [1:0] sy,
                                      logic xh, logic yh);
      return {ft, gt, ht, ha, hb, sx, sy, xh, yh};
   endfunction

   function automatic void ev(input logic [47:0] c, input logic [3:0] f, input logic [3:0] g,
                              input logic h1, input logic d, input logic a,
                              output logic x, output logic y, output logic fo,
                              output logic go, output logic ho);
      logic ha, hb;
      fo = c[32 + int'(f)];
      go = c[16 + int'(g)];
      ha = c[7] ? fo : d;
      hb = c[6] ? go : a;
      ho = c[8 + int'({h1, hb, ha})];
      x  = c[1] ? ho : fo;
      y  = c[0] ? ho : go;
   endfunction

   function automatic logic pick(logic [1:0] s, logic fo, logic go, logic ho, logic d);
      case (s)
         2'd0: return fo;
         2'd1: return go;
         2'd2: return ho;
         default: return d;
      endcase
   endfunction

   task automatic tick(input logic [4:0] m, input string rc, input string rq);
      exp_t e;
      logic x, y, fo, go, ho;
      @(negedge clk);
      rst = n_rst; ce = n_ce; cfg_en = n_en; cfg_si = n_si;
      f_in = n_f; g_in = n_g; h1_in = n_h1; din = n_din; alt_in = n_alt;
      ev(mcfg, n_f, n_g, n_h1, n_din, n_alt, x, y, fo, go, ho);
      if (n_rst) begin
         mqx = 0; mqy = 0;
      end else if (!n_en && n_ce) begin
         mqx = pick(mcfg[5:4], fo, go, ho, n_din);
         mqy = pick(mcfg[3:2], fo, go, ho, n_din);
      end
      if (n_en) mcfg = {mcfg[46:0], n_si};
      ev(mcfg, n_f, n_g, n_h1, n_din, n_alt, x, y, fo, go, ho);
      e.x = ovr_en ? ovr_x : x; e.y = y; e.qx = mqx; e.qy = mqy; e.so = mcfg[47];
      e.m = m; e.rc = rc; e.rq = rq;
      sb.push_back(e);
   endtask

   task automatic load(input logic [47:0] img);
      n_en = 1; n_ce = 1; n_rst = 0;
      for (int i = 0; i < 48; i++) begin
         n_si = img[47 - i];
         n_din = 1'($urandom);
         tick(M_SO | M_QX | M_QY, "R4", "R7");
      end
      n_en = 0;
   endtask

   task automatic sweep(input int n, input string rc);
      for (int k = 0; k < n; k++) begin
         n_f = k[3:0]; n_g = 4'($urandom);
         if (n == 256) n_g = k[7:4];
         n_h1 = 1'($urandom); n_din = 1'($urandom); n_alt = 1'($urandom);
         n_ce = ($urandom % 4) != 0;
         tick(M_X | M_Y | M_QX | M_QY | M_SO, rc, n_ce ? "R5" : "R6");
      end
   endtask

   task automatic chk(input logic got, input logic exp, input string req, input string nm);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s got=%0b expected=%0b at %0t", req, nm, got, exp, $time);
      end
   endtask

   // monitor: compare one scoreboard item after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            if (e.m & M_X)  chk(x_o,    e.x,  e.rc, "x_o");
            if (e.m & M_Y)  chk(y_o,    e.y,  e.rc, "y_o");
            if (e.m & M_SO) chk(cfg_so, e.so, e.rc, "cfg_so");
            if (e.m & M_QX) chk(qx_o,   e.qx, e.rq, "qx_o");
            if (e.m & M_QY) chk(qy_o,   e.qy, e.rq, "qy_o");
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [47:0] c;
      logic [15:0] par4;
      logic [31:0] t5;
      // R8 reset state
      n_rst = 1; n_ce = 1; n_en = 0;
      repeat (3) tick(M_QX | M_QY, "R8", "R8");
      n_rst = 0;

      // R1 plain F/G reads
      load(mk(16'($urandom), 16'($urandom), 8'($urandom), 0, 0, 2'd0, 2'd1, 0, 0));
      sweep(256, "R1");
      // R2 H with mixed selectors, R3 output selection
      load(mk(16'($urandom), 16'($urandom), 8'($urandom), 1, 0, 2'd2, 2'd3, 1, 0));
      sweep(256, "R2");
      load(mk(16'($urandom), 16'($urandom), 8'($urandom), 0, 1, 2'd3, 2'd2, 0, 1));
      sweep(256, "R3");
      c = {$urandom, 16'($urandom)};
      load(c);
      sweep(128, "R3");

      // R9 nine-input parity
      for (int k = 0; k < 16; k++) par4[k] = ^k[3:0];
      load(mk(par4, par4, 8'h96, 1, 1, 2'd2, 2'd0, 1, 0));
      ovr_en = 1;
      for (int k = 0; k < 512; k++) begin
         n_f = k[3:0]; n_g = k[7:4]; n_h1 = k[8];
         n_din = 1'($urandom); n_alt = 1'($urandom); n_ce = 1;
         ovr_x = ^k[8:0];
         tick(M_X | M_QX | M_QY, "R9", "R5");
      end
      ovr_en = 0;

      // R10 arbitrary five-input function
      t5 = $urandom;
      load(mk(t5[15:0], t5[31:16], 8'hCA, 1, 1, 2'd2, 2'd3, 1, 0));
      ovr_en = 1;
      for (int k = 0; k < 32; k++) begin
         n_f = k[3:0]; n_g = k[3:0]; n_h1 = k[4];
         n_din = 1'($urandom); n_alt = 1'($urandom); n_ce = 1;
         ovr_x = t5[k];
         tick(M_X | M_QX | M_QY, "R10", "R5");
      end
      ovr_en = 0;

      // R8 reset under ce and during load keeps configuration
      n_ce = 1; n_din = 1;
      repeat (4) tick(M_QX | M_QY, "R5", "R5");
      n_rst = 1;
      repeat (2) tick(M_QX | M_QY | M_X | M_Y, "R8", "R8");
      n_en = 1; n_si = 1;
      tick(M_QX | M_QY, "R8", "R8");
      n_en = 0; n_si = 0; n_rst = 0;
      sweep(32, "R8");

      // R6 long hold with ce low
      n_ce = 0;
      for (int k = 0; k < 16; k++) begin
         n_f = 4'($urandom); n_g = 4'($urandom); n_din = 1'($urandom);
         tick(M_QX | M_QY, "R6", "R6");
      end

      repeat (3) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule